// File: doc/BRIEF.md
# Power-Pulsing Phase Controller

This block steps a multichannel front-end readout chip through four operating phases to save power between acquisition windows. Decoded command pulses from the chip's serial link tell it which phase to enter. For each phase it drives a fixed pattern of domain controls:

- bias enables for the preamplifier, the shaper and the converter;
- the converter clock gate;
- the power switches for the processing logic and its memory;
- a selector that drops the configuration registers to a data-retention supply.

Moving down in power happens at the next clock edge. Moving up is sequenced:

- When leaving sleep, the processing domain is powered and held in reset for a programmable count.
- Before sampling, the analog biases are turned on a programmable number of settle cycles ahead of the converter clock.

A command that arrives during a sequenced transition is held in a one-entry slot and executed once the controller is stable again. A status output shows when the reported phase has been fully reached.

Top module: `pwr_phase_ctrl`

## Requirements
- R1: After reset the phase is sleep (phase code 0) with ready high. Every bias enable, the converter clock, processing power, memory power and processing reset are low, and configuration retention is high.
- R2: In the stable sampling phase (code 3), all three bias enables, the converter clock, processing power and memory power are high. Processing reset and configuration retention are low.
- R3: In the stable non-sampling (code 1) and read (code 2) phases, the bias enables and converter clock are low, processing and memory power are high, and processing reset and configuration retention are low.
- R4: A sleep command from any stable phase reports sleep (code 0) at the next edge. Analog, processing and memory controls are then all low and configuration retention is high.
- R5: Leaving sleep powers processing and memory and holds the processing reset high with ready low for max(rst_cycles_i,1) cycles. Only after that is the requested phase reported.
- R6: Entering sampling holds all bias enables high with the converter clock gated for max(settle_cycles_i,1) cycles before the clock is enabled.
- R7: Changing from sampling to non-sampling or read, or between non-sampling and read, completes at the next edge with ready staying high.
- R8: A command received while ready is low is stored in a one-entry slot, where a later command replaces an earlier one. The stored command is executed at the first edge after ready returns high.
- R9: When several command pulses are high in the same cycle, the priority is sleep, then pause (non-sampling), then read, then sample.
- R10: A command for the phase already reported while ready is high has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_sample_i | input | 1 | Enter sampling phase (pulse) |
| cmd_pause_i | input | 1 | Enter non-sampling phase (pulse) |
| cmd_read_i | input | 1 | Enter read phase (pulse) |
| cmd_sleep_i | input | 1 | Enter sleep phase (pulse) |
| rst_cycles_i | input | CNT_W | Processing reset hold length on sleep exit |
| settle_cycles_i | input | CNT_W | Bias settle length before converter clock |
| phase_o | output | 2 | Reported phase: 0 sleep, 1 non-sampling, 2 read, 3 sampling |
| ready_o | output | 1 | High when no transition is in progress |
| preamp_bias_en_o | output | 1 | Preamplifier bias enable |
| shaper_bias_en_o | output | 1 | Shaper bias enable |
| adc_bias_en_o | output | 1 | Converter bias enable |
| adc_clk_en_o | output | 1 | Converter clock gate enable |
| dsp_pwr_en_o | output | 1 | Processing logic power switch |
| dsp_rst_o | output | 1 | Processing logic reset, active high |
| ram_pwr_en_o | output | 1 | Memory power switch |
| cfg_retain_o | output | 1 | Configuration registers at retention supply |

## Verification
The stimulus covers four kinds of command pattern:

- single upward steps out of sleep, which separate a read target (reset window only) from a sampling target (reset then settle window);
- settle and reset counts of zero against non-zero ones, which exposes off-by-one errors in the window counters;
- single downward and sideways steps, which show that only rising power is sequenced;
- overlapping pulses, either several in one cycle or arriving during a window, which tell apart the priority order, the replace-on-newer rule of the slot, and the dropping of a command that repeats the current phase.

// File: rtl/pwr_phase_pkg.sv
package pwr_phase_pkg;
  typedef enum logic [1:0] {
    PH_SLEEP  = 2'd0,
    PH_PAUSE  = 2'd1,
    PH_READ   = 2'd2,
    PH_SAMPLE = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_STABLE = 2'd0,
    ST_RST    = 2'd1,
    ST_SETTLE = 2'd2
  } seq_e;
endpackage

// File: rtl/pwr_cmd_queue.sv
module pwr_cmd_queue
  import pwr_phase_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cmd_sample_i,
  input  logic   cmd_pause_i,
  input  logic   cmd_read_i,
  input  logic   cmd_sleep_i,
  input  logic   accept_i,
  output logic   cmd_vld_o,
  output phase_e cmd_ph_o
);
  logic   new_vld;
  phase_e new_ph;
  logic   pend_vld_q;
  phase_e pend_ph_q;

  always_comb begin
    new_vld = cmd_sleep_i | cmd_pause_i | cmd_read_i | cmd_sample_i;
    if (cmd_sleep_i)      new_ph = PH_SLEEP;
    else if (cmd_pause_i) new_ph = PH_PAUSE;
    else if (cmd_read_i)  new_ph = PH_READ;
    else                  new_ph = PH_SAMPLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_q <= 1'b0;
      pend_ph_q  <= PH_SLEEP;
    end else if (!accept_i && new_vld) begin
      pend_vld_q <= 1'b1;
      pend_ph_q  <= new_ph;
    end else if (accept_i) begin
      pend_vld_q <= 1'b0;
    end
  end

  assign cmd_vld_o = new_vld | pend_vld_q;
  assign cmd_ph_o  = new_vld ? new_ph : pend_ph_q;
endmodule

// File: rtl/pwr_phase_seq.sv
module pwr_phase_seq
  import pwr_phase_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  phase_e           cmd_ph_i,
  input  logic [CNT_W-1:0] rst_cycles_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output phase_e           phase_o,
  output logic             stable_o,
  output logic             in_rst_o,
  output logic             in_settle_o
);
  seq_e             st_q;
  phase_e           phase_q, tgt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_done;

  // windows last max(N,1) cycles
  assign cnt_done = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_STABLE;
      phase_q <= PH_SLEEP;
      tgt_q   <= PH_SLEEP;
      cnt_q   <= '0;
    end else begin
      unique case (st_q)
        ST_STABLE: begin
          if (cmd_vld_i && cmd_ph_i != phase_q) begin
            if (cmd_ph_i == PH_SLEEP) begin
              phase_q <= PH_SLEEP;
            end else if (phase_q == PH_SLEEP) begin
              st_q  <= ST_RST;
              cnt_q <= rst_cycles_i;
              tgt_q <= cmd_ph_i;
            end else if (cmd_ph_i == PH_SAMPLE) begin
              st_q  <= ST_SETTLE;
              cnt_q <= settle_cycles_i;
              tgt_q <= cmd_ph_i;
            end else begin
              phase_q <= cmd_ph_i;
            end
          end
        end
        ST_RST: begin
          if (cnt_done) begin
            if (tgt_q == PH_SAMPLE) begin
              st_q  <= ST_SETTLE;
              cnt_q <= settle_cycles_i;
            end else begin
              st_q    <= ST_STABLE;
              phase_q <= tgt_q;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        ST_SETTLE: begin
          if (cnt_done) begin
            st_q    <= ST_STABLE;
            phase_q <= tgt_q;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: st_q <= ST_STABLE;
      endcase
    end
  end

  assign phase_o     = phase_q;
  assign stable_o    = (st_q == ST_STABLE);
  assign in_rst_o    = (st_q == ST_RST);
  assign in_settle_o = (st_q == ST_SETTLE);
endmodule

// File: rtl/pwr_domain_map.sv
module pwr_domain_map
  import pwr_phase_pkg::*;
(
  input  phase_e phase_i,
  input  logic   stable_i,
  input  logic   in_rst_i,
  input  logic   in_settle_i,
  output logic   bias_en_o,
  output logic   adc_clk_en_o,
  output logic   dsp_pwr_en_o,
  output logic   dsp_rst_o,
  output logic   ram_pwr_en_o,
  output logic   cfg_retain_o
);
  logic sleeping, sampling;

  assign sleeping = stable_i && (phase_i == PH_SLEEP);
  assign sampling = stable_i && (phase_i == PH_SAMPLE);

  assign bias_en_o    = sampling | in_settle_i;
  assign adc_clk_en_o = sampling;
  assign dsp_pwr_en_o = !sleeping;
  assign ram_pwr_en_o = !sleeping;
  assign dsp_rst_o    = in_rst_i;
  assign cfg_retain_o = sleeping;
endmodule

// File: rtl/pwr_phase_ctrl.sv
module pwr_phase_ctrl
  import pwr_phase_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_sample_i,
  input  logic             cmd_pause_i,
  input  logic             cmd_read_i,
  input  logic             cmd_sleep_i,
  input  logic [CNT_W-1:0] rst_cycles_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output logic [1:0]       phase_o,
  output logic             ready_o,
  output logic             preamp_bias_en_o,
  output logic             shaper_bias_en_o,
  output logic             adc_bias_en_o,
  output logic             adc_clk_en_o,
  output logic             dsp_pwr_en_o,
  output logic             dsp_rst_o,
  output logic             ram_pwr_en_o,
  output logic             cfg_retain_o
);
  logic   cmd_vld, stable, in_rst, in_settle, bias_en;
  phase_e cmd_ph, phase;

  pwr_cmd_queue u_queue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_sample_i (cmd_sample_i),
    .cmd_pause_i  (cmd_pause_i),
    .cmd_read_i   (cmd_read_i),
    .cmd_sleep_i  (cmd_sleep_i),
    .accept_i     (stable),
    .cmd_vld_o    (cmd_vld),
    .cmd_ph_o     (cmd_ph)
  );

  pwr_phase_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cmd_vld_i       (cmd_vld),
    .cmd_ph_i        (cmd_ph),
    .rst_cycles_i    (rst_cycles_i),
    .settle_cycles_i (settle_cycles_i),
    .phase_o         (phase),
    .stable_o        (stable),
    .in_rst_o        (in_rst),
    .in_settle_o     (in_settle)
  );

  pwr_domain_map u_map (
    .phase_i      (phase),
    .stable_i     (stable),
    .in_rst_i     (in_rst),
    .in_settle_i  (in_settle),
    .bias_en_o    (bias_en),
    .adc_clk_en_o (adc_clk_en_o),
    .dsp_pwr_en_o (dsp_pwr_en_o),
    .dsp_rst_o    (dsp_rst_o),
    .ram_pwr_en_o (ram_pwr_en_o),
    .cfg_retain_o (cfg_retain_o)
  );

  assign phase_o          = phase;
  assign ready_o          = stable;
  assign preamp_bias_en_o = bias_en;
  assign shaper_bias_en_o = bias_en;
  assign adc_bias_en_o    = bias_en;
endmodule

// File: rtl/pwr_phase_ctrl_chk.sv
module pwr_phase_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_sleep_i,
  input logic [1:0] phase_o,
  input logic       ready_o,
  input logic       preamp_bias_en_o,
  input logic       shaper_bias_en_o,
  input logic       adc_bias_en_o,
  input logic       adc_clk_en_o,
  input logic       dsp_pwr_en_o,
  input logic       dsp_rst_o,
  input logic       ram_pwr_en_o,
  input logic       cfg_retain_o
);
  assert_clk_needs_bias_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_clk_en_o |-> (adc_bias_en_o && preamp_bias_en_o && shaper_bias_en_o));

  assert_bias_before_clk_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_clk_en_o) |-> $past(adc_bias_en_o));

  assert_rst_needs_pwr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsp_rst_o |-> (dsp_pwr_en_o && ram_pwr_en_o && !ready_o));

  assert_retain_all_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_retain_o |-> (!dsp_pwr_en_o && !ram_pwr_en_o && !adc_bias_en_o && !adc_clk_en_o));

  assert_sample_all_on_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && phase_o == 2'd3) |-> (adc_clk_en_o && dsp_pwr_en_o && ram_pwr_en_o && !cfg_retain_o));

  assert_sleep_next_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_sleep_i) |=> (phase_o == 2'd0 && cfg_retain_o));
endmodule

bind pwr_phase_ctrl pwr_phase_ctrl_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cmd_sleep_i      (cmd_sleep_i),
  .phase_o          (phase_o),
  .ready_o          (ready_o),
  .preamp_bias_en_o (preamp_bias_en_o),
  .shaper_bias_en_o (shaper_bias_en_o),
  .adc_bias_en_o    (adc_bias_en_o),
  .adc_clk_en_o     (adc_clk_en_o),
  .dsp_pwr_en_o     (dsp_pwr_en_o),
  .dsp_rst_o        (dsp_rst_o),
  .ram_pwr_en_o     (ram_pwr_en_o),
  .cfg_retain_o     (cfg_retain_o)
);

// File: tb/sim_pwr_phase_ctrl.sv
module sim_pwr_phase_ctrl;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             c_smp = 1'b0, c_pau = 1'b0, c_rd = 1'b0, c_slp = 1'b0;
  logic [CNT_W-1:0] rst_cyc = '0, set_cyc = '0;
  logic [1:0]       phase;
  logic             ready, pre_b, shp_b, adc_b, adc_c, dsp_p, dsp_r, ram_p, cfg_r;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_phase_ctrl #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_sample_i(c_smp), .cmd_pause_i(c_pau), .cmd_read_i(c_rd), .cmd_sleep_i(c_slp),
    .rst_cycles_i(rst_cyc), .settle_cycles_i(set_cyc),
    .phase_o(phase), .ready_o(ready),
    .preamp_bias_en_o(pre_b), .shaper_bias_en_o(shp_b), .adc_bias_en_o(adc_b),
    .adc_clk_en_o(adc_c), .dsp_pwr_en_o(dsp_p), .dsp_rst_o(dsp_r),
    .ram_pwr_en_o(ram_p), .cfg_retain_o(cfg_r)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // packs {pre,shp,adc_b,adc_c,dsp_p,dsp_r,ram_p,cfg_r}
  function automatic int dom();
    return {pre_b, shp_b, adc_b, adc_c, dsp_p, dsp_r, ram_p, cfg_r};
  endfunction

  localparam int DOM_SLEEP  = 8'b0000_0001;
  localparam int DOM_MID    = 8'b0000_1010;
  localparam int DOM_SAMPLE = 8'b1111_1010;

  // called at a negedge; returns at the negedge after the capture edge
  task automatic pulse(input bit s, input bit p, input bit r, input bit z);
    c_smp = s; c_pau = p; c_rd = r; c_slp = z;
    @(negedge clk);
    c_smp = 0; c_pau = 0; c_rd = 0; c_slp = 0;
  endtask

  task automatic count_rst(output int n);
    n = 0;
    while (dsp_r && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic count_settle(output int n);
    n = 0;
    while (adc_b && !adc_c && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, 0);
    chk("R1 ready", ready, 1);
    chk("R1 domains", dom(), DOM_SLEEP);
  endtask

  task automatic t_sleep_to_read();
    int n;
    rst_cyc = 3;
    pulse(0, 0, 1, 0);
    chk("R5 power during reset", dsp_p & ram_p & !ready, 1);
    count_rst(n);
    chk("R5 reset length", n, 3);
    chk("R5 phase after reset", phase, 2);
    chk("R3 read domains", dom(), DOM_MID);
  endtask

  task automatic t_read_to_sample();
    int n;
    set_cyc = 4;
    pulse(1, 0, 0, 0);
    count_settle(n);
    chk("R6 settle length", n, 4);
    chk("R2 phase", phase, 3);
    chk("R2 sample domains", dom(), DOM_SAMPLE);
  endtask

  task automatic t_down_steps();
    pulse(0, 1, 0, 0);
    chk("R7 pause phase", phase, 1);
    chk("R7 ready kept", ready, 1);
    chk("R3 pause domains", dom(), DOM_MID);
    pulse(0, 0, 1, 0);
    chk("R7 read phase", phase, 2);
  endtask

  task automatic t_ignore_same();
    pulse(0, 0, 1, 0);
    chk("R10 phase", phase, 2);
    chk("R10 ready", ready, 1);
    chk("R10 domains", dom(), DOM_MID);
  endtask

  task automatic t_priority();
    pulse(1, 0, 0, 1);
    chk("R9 sleep wins", phase, 0);
    chk("R4 sleep domains", dom(), DOM_SLEEP);
  endtask

  task automatic t_zero_counts();
    int n;
    rst_cyc = 0; set_cyc = 0;
    pulse(1, 0, 0, 0);
    count_rst(n);
    chk("R5 zero reset count", n, 1);
    count_settle(n);
    chk("R6 zero settle count", n, 1);
    chk("R2 phase", phase, 3);
    pulse(0, 1, 1, 0);
    chk("R9 pause over read", phase, 1);
  endtask

  task automatic t_queue();
    int n;
    pulse(0, 0, 0, 1);
    chk("R4 sleep from pause", phase, 0);
    rst_cyc = 5; set_cyc = 2;
    pulse(0, 0, 1, 0);
    pulse(0, 1, 0, 0);
    pulse(1, 0, 0, 0);
    count_rst(n);
    chk("R5 reset with queued cmds", n, 3);
    chk("R8 first target reached", phase, 2);
    chk("R8 ready", ready, 1);
    @(negedge clk);
    count_settle(n);
    chk("R8 queued sample settle", n, 2);
    chk("R8 newest kept", phase, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_sleep_to_read();
    t_read_to_sample();
    t_down_steps();
    t_ignore_same();
    t_priority();
    t_zero_counts();
    t_queue();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule